// File: doc/BRIEF.md
# Encryption Pass Scheduler

This control block orders the passes of a configurable lattice-encryption pipeline that shares one streaming number-theoretic transform. A pulse on `start` accepts a configuration made of the transform size, given as log2 N, and the computational level. The block then runs Level+2 identical passes back to back. The first pass handles the special prime. Each of the Level+1 passes that follow handles one data prime and carries a modulus-switch step. Every pass lasts exactly L = 2N + 45·log2(N) + 2 cycles, so a run takes (Level+2)·L cycles in total.

Within a pass, a cycle counter and derived stage flags control the working and parameter memories. The same counter fires one-cycle start strobes for three transform lanes that run together (the random vector and the two error vectors), for the multiply-add stage and for the modulus-switch stage. A one-cycle `done` pulse closes the run. The datapath units themselves lie outside this block, and the schedule assumes only the latencies that the closed-form pass length implies.

Top module: `enc_pass_sched`

## Requirements
- R1: While reset is held and afterwards until the first start, busy, done, pass_start, xf_start, mac_start and msw_start are all 0.
- R2: A start seen while idle latches cfg_logn and cfg_level. In the next cycle busy is 1, pass_idx is 0, cyc_cnt is 0 and pass_start is 1. pass_start is 1 only in cycle 0 of each pass.
- R3: Each pass lasts exactly L = 2·2^lg + 45·lg + 2 cycles, where lg is the latched log2 N.
- R4: A run makes Level+2 passes. pass_idx is 0 for the special prime and then 1 to Level+1 in order. last_pass is 1 for all of pass Level+1 and at no other time.
- R5: xf_start drives all three bits to 1 together for exactly one cycle, in pass cycle 0 of every pass, and is 3'b000 at all other times.
- R6: msw_start pulses in pass cycle 0 of every pass with pass_idx ≥ 1, and never in the special-prime pass.
- R7: mac_start pulses in pass cycle N + 45·lg of every pass.
- R8: In pass cycles [0, N), wm_rd_en and stg_in are 1. In cycles [N+45·lg, 2N+45·lg), stg_out is 1. In cycles (N+45·lg, 2N+45·lg], wm_wr_en is 1. pm_rd_en is 1 in pass cycle 0 only. All of these signals are 0 at every other time.
- R9: busy stays 1 for exactly (Level+2)·L cycles. done is a one-cycle pulse in the first cycle after busy falls.
- R10: A start while busy is ignored, and changes on cfg_logn or cfg_level during a run do not alter the schedule.
- R11: A cfg_logn value below LOGN_MIN is treated as LOGN_MIN, and a value above LOGN_MAX is treated as LOGN_MAX.
- R12: Within a pass, cyc_cnt counts 0, 1, … L−1 by one per cycle. When the block is idle, cyc_cnt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (sampled when idle) |
| cfg_logn | input | LGW | log2 of the transform size |
| cfg_level | input | LVW | Computational level |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass_idx | output | PW | Modulus index of the current pass (0 = special prime) |
| cyc_cnt | output | CW | Cycle within the current pass |
| last_pass | output | 1 | Current pass is the final data prime |
| pass_start | output | 1 | First cycle of a pass |
| stg_in | output | 1 | Input streaming stage flag |
| stg_out | output | 1 | Output streaming stage flag |
| pm_rd_en | output | 1 | Parameter memory fetch for this modulus |
| wm_rd_en | output | 1 | Working memory read enable |
| wm_wr_en | output | 1 | Working memory write enable |
| xf_start | output | 3 | Start strobes for the three transform lanes |
| mac_start | output | 1 | Multiply-add stage start strobe |
| msw_start | output | 1 | Modulus-switch stage start strobe |

## Verification
The hardest situation to reach from the ports is a wrong pass boundary deep into a run: for example, a last pass that runs one cycle long, or an out-of-range size that is clamped the wrong way. These errors only show after thousands of cycles. The bench therefore shrinks the size range, so that every clamped and in-range size can be crossed with every level. It predicts every output in every cycle of each run from the cycle offset since start. During one run per sweep it also raises start again and scrambles the configuration inputs mid-run.

// File: rtl/enc_sched_pkg.sv
package enc_sched_pkg;
  // Cycles of one full transform pass for log2 size lg.
  function automatic int pass_len(int lg);
    return 2 * (1 << lg) + 45 * lg + 2;
  endfunction

  // Pass cycle in which the first transformed coefficient leaves the pipe.
  function automatic int out_first(int lg);
    return (1 << lg) + 45 * lg;
  endfunction
endpackage

// File: rtl/enc_sched_cfg.sv
module enc_sched_cfg import enc_sched_pkg::*; #(
  parameter int LOGN_MIN = 12,
  parameter int LOGN_MAX = 16,
  parameter int LGW      = 5,
  parameter int LVW      = 5,
  parameter int CW       = 18
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           run,
  input  logic [LGW-1:0] cfg_logn,
  input  logic [LVW-1:0] cfg_level,
  output logic [LGW-1:0] logn_q,
  output logic [LVW-1:0] level_q,
  output logic [CW-1:0]  len,
  output logic [CW-1:0]  in_len,
  output logic [CW-1:0]  out_at
);
  logic [LGW-1:0] logn_clamped;

  always_comb begin
    if (cfg_logn < LGW'(LOGN_MIN))      logn_clamped = LGW'(LOGN_MIN);
    else if (cfg_logn > LGW'(LOGN_MAX)) logn_clamped = LGW'(LOGN_MAX);
    else                                logn_clamped = cfg_logn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      logn_q  <= LGW'(LOGN_MIN);
      level_q <= '0;
    end else if (load) begin
      logn_q  <= logn_clamped;
      level_q <= cfg_level;
    end
  end

  assign len    = CW'(pass_len(int'(logn_q)));
  assign in_len = CW'(32'd1 << logn_q);
  assign out_at = CW'(out_first(int'(logn_q)));

  // R10
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(logn_q) && $stable(level_q)));

  // R11
  logn_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (logn_q >= LGW'(LOGN_MIN) && logn_q <= LGW'(LOGN_MAX)));
endmodule

// File: rtl/enc_sched_count.sv
module enc_sched_count #(
  parameter int CW  = 18,
  parameter int LVW = 5,
  parameter int PW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CW-1:0]  len,
  input  logic [LVW-1:0] level_q,
  output logic           accept,
  output logic           busy,
  output logic           done,
  output logic [CW-1:0]  cyc,
  output logic [PW-1:0]  pass,
  output logic [PW-1:0]  last_idx
);
  logic pass_end;

  assign accept   = start && !busy;
  assign last_idx = PW'(level_q) + PW'(1);
  assign pass_end = busy && (cyc == len - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cyc  <= '0;
      pass <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        cyc  <= '0;
        pass <= '0;
      end else if (pass_end) begin
        cyc <= '0;
        if (pass == last_idx) begin
          busy <= 1'b0;
          done <= 1'b1;
          pass <= '0;
        end else begin
          pass <= pass + PW'(1);
        end
      end else if (busy) begin
        cyc <= cyc + CW'(1);
      end
    end
  end

  // R9
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R3
  pass_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && cyc == '0) |-> ($past(cyc) == $past(len) - CW'(1)));

  // R4
  pass_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pass <= last_idx));

  // R12
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && cyc != '0) |-> (cyc == $past(cyc) + CW'(1)));
endmodule

// File: rtl/enc_sched_dec.sv
module enc_sched_dec #(
  parameter int CW = 18,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic [CW-1:0] cyc,
  input  logic [PW-1:0] pass,
  input  logic [PW-1:0] last_idx,
  input  logic [CW-1:0] in_len,
  input  logic [CW-1:0] out_at,
  output logic          pass_start,
  output logic          last_pass,
  output logic          stg_in,
  output logic          stg_out,
  output logic          pm_rd_en,
  output logic          wm_rd_en,
  output logic          wm_wr_en,
  output logic [2:0]    xf_start,
  output logic          mac_start,
  output logic          msw_start
);
  logic at_zero;
  logic [CW-1:0] out_end;

  assign at_zero    = busy && (cyc == '0);
  assign out_end    = out_at + in_len;
  assign pass_start = at_zero;
  assign last_pass  = busy && (pass == last_idx);
  assign stg_in     = busy && (cyc < in_len);
  assign stg_out    = busy && (cyc >= out_at) && (cyc < out_end);
  assign pm_rd_en   = at_zero;
  assign wm_rd_en   = stg_in;
  assign wm_wr_en   = busy && (cyc > out_at) && (cyc <= out_end);
  assign mac_start  = busy && (cyc == out_at);
  assign msw_start  = at_zero && (pass != '0);

  for (genvar g = 0; g < 3; g++) begin : g_lane
    assign xf_start[g] = at_zero;
  end

  // R5
  xf_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xf_start != 3'b000) |-> (xf_start == 3'b111 && pass_start));

  // R6
  msw_data_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msw_start |-> (pass != '0 && xf_start == 3'b111));

  // R8
  wr_follows_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stg_out |=> wm_wr_en);

  // R7
  mac_in_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_start |-> (stg_out && !wm_wr_en));
endmodule

// File: rtl/enc_pass_sched.sv
module enc_pass_sched import enc_sched_pkg::*; #(
  parameter int LOGN_MIN = 12,
  parameter int LOGN_MAX = 16,
  parameter int LVW      = 5,
  localparam int LGW     = $clog2(LOGN_MAX + 2),
  localparam int CW      = $clog2(pass_len(LOGN_MAX) + 1),
  localparam int PW      = LVW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [LGW-1:0] cfg_logn,
  input  logic [LVW-1:0] cfg_level,
  output logic           busy,
  output logic           done,
  output logic [PW-1:0]  pass_idx,
  output logic [CW-1:0]  cyc_cnt,
  output logic           last_pass,
  output logic           pass_start,
  output logic           stg_in,
  output logic           stg_out,
  output logic           pm_rd_en,
  output logic           wm_rd_en,
  output logic           wm_wr_en,
  output logic [2:0]     xf_start,
  output logic           mac_start,
  output logic           msw_start
);
  logic           accept;
  logic [LGW-1:0] logn_q;
  logic [LVW-1:0] level_q;
  logic [CW-1:0]  len, in_len, out_at;
  logic [PW-1:0]  last_idx;

  enc_sched_cfg #(.LOGN_MIN(LOGN_MIN), .LOGN_MAX(LOGN_MAX), .LGW(LGW),
                  .LVW(LVW), .CW(CW)) cfg_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .run(busy),
    .cfg_logn(cfg_logn), .cfg_level(cfg_level),
    .logn_q(logn_q), .level_q(level_q),
    .len(len), .in_len(in_len), .out_at(out_at));

  enc_sched_count #(.CW(CW), .LVW(LVW), .PW(PW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len), .level_q(level_q),
    .accept(accept), .busy(busy), .done(done), .cyc(cyc_cnt),
    .pass(pass_idx), .last_idx(last_idx));

  enc_sched_dec #(.CW(CW), .PW(PW)) dec_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cyc(cyc_cnt), .pass(pass_idx),
    .last_idx(last_idx), .in_len(in_len), .out_at(out_at),
    .pass_start(pass_start), .last_pass(last_pass), .stg_in(stg_in),
    .stg_out(stg_out), .pm_rd_en(pm_rd_en), .wm_rd_en(wm_rd_en),
    .wm_wr_en(wm_wr_en), .xf_start(xf_start), .mac_start(mac_start),
    .msw_start(msw_start));
endmodule

// File: tb/enc_pass_sched_tb_top.sv
module enc_pass_sched_tb_top;
  localparam int LMIN = 3;
  localparam int LMAX = 5;
  localparam int LVW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] cfg_logn = '0;
  logic [LVW-1:0] cfg_level = '0;
  logic busy, done, last_pass, pass_start, stg_in, stg_out;
  logic pm_rd_en, wm_rd_en, wm_wr_en, mac_start, msw_start;
  logic [2:0] xf_start;
  logic [LVW:0] pass_idx;
  logic [8:0] cyc_cnt;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  enc_pass_sched #(.LOGN_MIN(LMIN), .LOGN_MAX(LMAX), .LVW(LVW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_logn(cfg_logn),
    .cfg_level(cfg_level), .busy(busy), .done(done), .pass_idx(pass_idx),
    .cyc_cnt(cyc_cnt), .last_pass(last_pass), .pass_start(pass_start),
    .stg_in(stg_in), .stg_out(stg_out), .pm_rd_en(pm_rd_en),
    .wm_rd_en(wm_rd_en), .wm_wr_en(wm_wr_en), .xf_start(xf_start),
    .mac_start(mac_start), .msw_start(msw_start));

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_checks(string req);
    chk(req, "busy", int'(busy), 0);
    chk(req, "done", int'(done), 0);
    chk(req, "pass_start", int'(pass_start), 0);
    chk(req, "xf_start", int'(xf_start), 0);
    chk(req, "mac_start", int'(mac_start), 0);
    chk(req, "msw_start", int'(msw_start), 0);
  endtask

  task automatic run(int lg_in, int lv, bit disturb);
    int lg, n, plen, total, ofs, p, c;
    bit on;
    string rs;
    lg    = (lg_in < LMIN) ? LMIN : ((lg_in > LMAX) ? LMAX : lg_in);
    n     = 1 << lg;
    plen  = (n << 1) + lg * 45 + 2;
    ofs   = n + lg * 45;
    total = (lv + 2) * plen;
    rs    = (lg_in != lg) ? "R11" : "R3";
    @(negedge clk);
    start = 1'b1; cfg_logn = 3'(lg_in); cfg_level = LVW'(lv);
    @(negedge clk);
    start = 1'b0; cfg_logn = 3'(7 - lg_in); cfg_level = LVW'(~lv);
    for (int t = 0; t <= total + 1; t++) begin
      on = (t < total);
      p  = on ? t / plen : 0;
      c  = on ? t % plen : 0;
      chk("R9", "busy", int'(busy), int'(on));
      chk("R9", "done", int'(done), int'(t == total));
      chk(disturb ? "R10" : "R4", "pass_idx", int'(pass_idx), p);
      chk("R4", "last_pass", int'(last_pass), int'(on && p == lv + 1));
      chk(rs, "cyc_cnt", int'(cyc_cnt), c);
      chk("R12", "cyc_cnt", int'(cyc_cnt), c);
      chk("R2", "pass_start", int'(pass_start), int'(on && c == 0));
      chk("R5", "xf_start", int'(xf_start), (on && c == 0) ? 7 : 0);
      chk("R6", "msw_start", int'(msw_start), int'(on && c == 0 && p > 0));
      chk("R7", "mac_start", int'(mac_start), int'(on && c == ofs));
      chk("R8", "pm_rd_en", int'(pm_rd_en), int'(on && c == 0));
      chk("R8", "wm_rd_en", int'(wm_rd_en), int'(on && c < n));
      chk("R8", "stg_in", int'(stg_in), int'(on && c < n));
      chk("R8", "stg_out", int'(stg_out), int'(on && c >= ofs && c < ofs + n));
      chk("R8", "wm_wr_en", int'(wm_wr_en), int'(on && c > ofs && c <= ofs + n));
      if (disturb && t == 3) begin
        start = 1'b1; cfg_logn = 3'(LMIN); cfg_level = '0;
      end
      if (disturb && t == 4) start = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_checks("R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    idle_checks("R1");
    for (int lg = LMIN - 1; lg <= LMAX + 1; lg++)
      for (int lv = 0; lv < (1 << LVW); lv++)
        run(lg, lv, lv == 1);
    @(negedge clk);
    idle_checks("R9");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule